// File: doc/BRIEF.md
# Threshold-Driven FIFO Request and Draining Controller

This block sits between a host (processor or DMA engine) and a two-wire serial bus core. It holds one transmit FIFO and one receive FIFO. From their fill levels it derives the ready flags, the DMA request lines and the end-of-transfer draining flags that tell the host how much data to move and when. The host side works in bursts of a programmable size, the threshold field plus one. The core side may pop or push a byte whenever the FIFO allows it, with no threshold applied.

Status flags are sticky and cleared by writing one. A flag whose condition still holds at the clear sets again. A per-bit mask folds the flags into a single interrupt line, and the unmasked raw flags stay visible. The draining flags cover transfers whose length is not a whole number of bursts. They report the leftover count, so the host can move exactly the bytes that remain. The FIFO depth is a parameter and is also visible on an output.

Top module: `xfr_reqctl`

## Requirements
- R1: The FIFO depth equals parameter DEPTH and `fifo_depth` shows it. Both FIFOs deliver bytes in the order they were written, and `tx_level`/`rx_level` give the byte counts.
- R2: Flag bit 0 (receive ready) sets on the clock edge at which `rx_level` is at least `rx_thresh`+1.
- R3: A 1 in `flag_clr` clears the matching flag bit. If that flag's condition still holds in the clearing cycle, the bit stays set.
- R4: With `rx_dma_en` high, `rx_dma_req` rises one cycle after `rx_level` reaches `rx_thresh`+1. It falls at the edge that accepts the (`rx_thresh`+1)-th host read, and it re-arms one cycle later if the level still meets the threshold. It stays low while `rx_dma_en` is low.
- R5: With `tx_dma_en` high, `tx_dma_req` rises one cycle after the TX FIFO becomes empty. It stays high while fewer than `tx_thresh`+1 host writes have been accepted, and it falls at the edge that accepts the last write of that burst.
- R6: Flag bit 4 (access error) sets after a host read while the RX FIFO is empty, or after a host write while the TX FIFO is full. The rejected access leaves the level unchanged.
- R7: Flag bit 2 (receive drain) sets when `xfer_done` pulses while `rx_drain_en` is high and 0 < `rx_level` < `rx_thresh`+1. `rx_level` then gives the leftover count.
- R8: Flag bit 3 (transmit drain) sets when `tx_drain_en` is high and 0 < `tx_remain` < `tx_thresh`+1. With the enable low it never sets.
- R9: A pulse on `tx_clr` or `rx_clr` empties that FIFO and clears its DMA request on the next edge.
- R10: `core_tx_avail` is high whenever the TX FIFO is not empty, and `core_rx_space` is high whenever the RX FIFO is not full, regardless of thresholds.
- R11: `irq` is the OR of `raw_flags` AND `irq_mask`. The mask has no effect on `raw_flags`.
- R12: Flag bit 1 (transmit ready) sets on an edge at which the TX FIFO has free space of at least `tx_thresh`+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_wr | input | 1 | Host writes a byte into the TX FIFO |
| host_wdata | input | WIDTH | Host write data |
| host_rd | input | 1 | Host pops a byte from the RX FIFO |
| host_rdata | output | WIDTH | Head of the RX FIFO |
| core_tx_rd | input | 1 | Core pops a byte from the TX FIFO |
| core_tx_data | output | WIDTH | Head of the TX FIFO |
| core_tx_avail | output | 1 | TX FIFO not empty |
| core_rx_wr | input | 1 | Core pushes a received byte |
| core_rx_data | input | WIDTH | Received byte from the core |
| core_rx_space | output | 1 | RX FIFO not full |
| tx_thresh | input | $clog2(DEPTH) | TX burst size minus one |
| rx_thresh | input | $clog2(DEPTH) | RX burst size minus one |
| tx_dma_en | input | 1 | Enable TX DMA requests |
| rx_dma_en | input | 1 | Enable RX DMA requests |
| tx_drain_en | input | 1 | Enable transmit-drain flag |
| rx_drain_en | input | 1 | Enable receive-drain flag |
| tx_clr | input | 1 | Flush TX FIFO and its DMA state |
| rx_clr | input | 1 | Flush RX FIFO and its DMA state |
| tx_remain | input | CW | Bytes the host still has to write |
| xfer_done | input | 1 | End-of-transfer strobe |
| flag_clr | input | 5 | Write-one-to-clear strobes per flag |
| irq_mask | input | 5 | Interrupt enable per flag |
| raw_flags | output | 5 | Unmasked sticky flags |
| irq | output | 1 | Combined interrupt |
| tx_dma_req | output | 1 | TX DMA request |
| rx_dma_req | output | 1 | RX DMA request |
| tx_level | output | $clog2(DEPTH+1) | TX FIFO fill level |
| rx_level | output | $clog2(DEPTH+1) | RX FIFO fill level |
| fifo_depth | output | $clog2(DEPTH+1) | Configured depth |

## Verification
The checker assumes the threshold fields are legal values below DEPTH. It also assumes that a clear strobe is a single-cycle event, so that a core push in the cycle after a clear does not hide the empty level. The stimulus changes thresholds only while the FIFOs are flushed. Each strobe is driven for exactly one cycle, with idle cycles between phases. The sweeps cover every threshold of a four-entry configuration, every fill count and every leftover count.

// File: rtl/xfr_pkg.sv
package xfr_pkg;
   localparam int NFLAG = 5;
   typedef enum logic [2:0] {
      FLG_RXRDY  = 3'd0,
      FLG_TXRDY  = 3'd1,
      FLG_RXDRN  = 3'd2,
      FLG_TXDRN  = 3'd3,
      FLG_ACCERR = 3'd4
   } flag_e;
endpackage

// File: rtl/xfr_fifo.sv
module xfr_fifo #(
   parameter int DEPTH = 32,
   parameter int WIDTH = 8,
   localparam int AW = $clog2(DEPTH),
   localparam int LW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic [LW-1:0]    level,
   output logic             full,
   output logic             empty
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("xfr_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr, rptr;
   logic             do_push, do_pop;

   assign full    = (level == LW'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else if (clr) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else begin
         if (do_push) wptr <= wptr + AW'(1);
         if (do_pop)  rptr <= rptr + AW'(1);
         case ({do_push, do_pop})
            2'b10:   level <= level + LW'(1);
            2'b01:   level <= level - LW'(1);
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/xfr_dma_req.sv
module xfr_dma_req #(
   parameter int TW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          clr,
   input  logic          arm,
   input  logic          step_evt,
   input  logic [TW-1:0] thresh,
   output logic          req
);
   logic          active;
   logic [TW-1:0] cnt;

   assign req = active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (clr || !en) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (!active) begin
         active <= arm;
         cnt    <= '0;
      end else if (step_evt) begin
         if (cnt == thresh) begin
            active <= 1'b0;
            cnt    <= '0;
         end else begin
            cnt <= cnt + TW'(1);
         end
      end
   end
endmodule

// File: rtl/xfr_reqctl.sv
module xfr_reqctl
   import xfr_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int WIDTH = 8,
   parameter int CW    = 8,
   localparam int TW = $clog2(DEPTH),
   localparam int LW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_wr,
   input  logic [WIDTH-1:0] host_wdata,
   input  logic             host_rd,
   output logic [WIDTH-1:0] host_rdata,
   input  logic             core_tx_rd,
   output logic [WIDTH-1:0] core_tx_data,
   output logic             core_tx_avail,
   input  logic             core_rx_wr,
   input  logic [WIDTH-1:0] core_rx_data,
   output logic             core_rx_space,
   input  logic [TW-1:0]    tx_thresh,
   input  logic [TW-1:0]    rx_thresh,
   input  logic             tx_dma_en,
   input  logic             rx_dma_en,
   input  logic             tx_drain_en,
   input  logic             rx_drain_en,
   input  logic             tx_clr,
   input  logic             rx_clr,
   input  logic [CW-1:0]    tx_remain,
   input  logic             xfer_done,
   input  logic [NFLAG-1:0] flag_clr,
   input  logic [NFLAG-1:0] irq_mask,
   output logic [NFLAG-1:0] raw_flags,
   output logic             irq,
   output logic             tx_dma_req,
   output logic             rx_dma_req,
   output logic [LW-1:0]    tx_level,
   output logic [LW-1:0]    rx_level,
   output logic [LW-1:0]    fifo_depth
);
   if (CW < 1 || CW > 31) begin : g_bad_cw
      $error("xfr_reqctl: CW must lie in 1..31");
   end

   logic tx_full, tx_empty, rx_full, rx_empty;
   logic [LW-1:0] tx_need, rx_need, tx_free;
   logic [NFLAG-1:0] cond;

   xfr_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .clr(tx_clr),
      .push(host_wr), .din(host_wdata),
      .pop(core_tx_rd), .dout(core_tx_data),
      .level(tx_level), .full(tx_full), .empty(tx_empty)
   );

   xfr_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .clr(rx_clr),
      .push(core_rx_wr), .din(core_rx_data),
      .pop(host_rd), .dout(host_rdata),
      .level(rx_level), .full(rx_full), .empty(rx_empty)
   );

   assign tx_need = LW'(tx_thresh) + LW'(1);
   assign rx_need = LW'(rx_thresh) + LW'(1);
   assign tx_free = LW'(DEPTH) - tx_level;

   xfr_dma_req #(.TW(TW)) u_txdma (
      .clk(clk), .rst_n(rst_n), .en(tx_dma_en), .clr(tx_clr),
      .arm(tx_empty), .step_evt(host_wr && !tx_full),
      .thresh(tx_thresh), .req(tx_dma_req)
   );

   xfr_dma_req #(.TW(TW)) u_rxdma (
      .clk(clk), .rst_n(rst_n), .en(rx_dma_en), .clr(rx_clr),
      .arm(rx_level >= rx_need), .step_evt(host_rd && !rx_empty),
      .thresh(rx_thresh), .req(rx_dma_req)
   );

   always_comb begin
      cond             = '0;
      cond[FLG_RXRDY]  = (rx_level >= rx_need);
      cond[FLG_TXRDY]  = (tx_free >= tx_need);
      cond[FLG_RXDRN]  = rx_drain_en && xfer_done && !rx_empty && (rx_level < rx_need);
      cond[FLG_TXDRN]  = tx_drain_en && (tx_remain != '0) && (32'(tx_remain) < 32'(tx_need));
      cond[FLG_ACCERR] = (host_rd && rx_empty) || (host_wr && tx_full);
   end

   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       q <= 1'b0;
         else if (cond[i]) q <= 1'b1;
         else              q <= q & ~flag_clr[i];
      end
      assign raw_flags[i] = q;
   end

   assign irq           = |(raw_flags & irq_mask);
   assign core_tx_avail = !tx_empty;
   assign core_rx_space = !rx_full;
   assign fifo_depth    = LW'(DEPTH);
endmodule

// File: rtl/xfr_reqctl_chk.sv
module xfr_reqctl_chk #(
   parameter int DEPTH = 32,
   localparam int TW = $clog2(DEPTH),
   localparam int LW = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          host_rd,
   input logic          rx_clr,
   input logic          tx_clr,
   input logic          rx_dma_en,
   input logic [TW-1:0] rx_thresh,
   input logic [4:0]    raw_flags,
   input logic          rx_dma_req,
   input logic          tx_dma_req,
   input logic [LW-1:0] rx_level,
   input logic [LW-1:0] tx_level
);
   assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level <= LW'(DEPTH)) && (tx_level <= LW'(DEPTH)));

   assert_rxrdy_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level >= LW'(rx_thresh) + LW'(1)) |=> raw_flags[0]);

   assert_rxrdy_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_flags[0]) |-> $past(rx_level >= LW'(rx_thresh) + LW'(1)));

   assert_rxdma_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_dma_en |=> !rx_dma_req);

   assert_accerr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && rx_level == '0) |=> raw_flags[4]);

   assert_rxclr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_clr |=> (rx_level == '0 && !rx_dma_req));

   assert_txclr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_clr |=> (tx_level == '0 && !tx_dma_req));
endmodule

bind xfr_reqctl xfr_reqctl_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .rx_clr(rx_clr), .tx_clr(tx_clr),
   .rx_dma_en(rx_dma_en), .rx_thresh(rx_thresh), .raw_flags(raw_flags),
   .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
   .rx_level(rx_level), .tx_level(tx_level)
);

// File: tb/xfr_reqctl_bench.sv
module xfr_reqctl_bench;
   localparam int DEPTH = 4;
   localparam int TW = 2;
   localparam int LW = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic host_wr = 0, host_rd = 0, core_tx_rd = 0, core_rx_wr = 0;
   logic [7:0] host_wdata = 0, core_rx_data = 0, host_rdata, core_tx_data;
   logic core_tx_avail, core_rx_space;
   logic [TW-1:0] tx_thresh = 0, rx_thresh = 0;
   logic tx_dma_en = 0, rx_dma_en = 0, tx_drain_en = 0, rx_drain_en = 0;
   logic tx_clr = 0, rx_clr = 0, xfer_done = 0;
   logic [7:0] tx_remain = 0;
   logic [4:0] flag_clr = 0, irq_mask = 0, raw_flags;
   logic irq, tx_dma_req, rx_dma_req;
   logic [LW-1:0] tx_level, rx_level, fifo_depth;

   int n_cmp = 0, n_bad = 0;

   always #2 clk = ~clk;

   xfr_reqctl #(.DEPTH(DEPTH), .WIDTH(8), .CW(8)) u_xfr_reqctl (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rd(host_rd), .host_rdata(host_rdata), .core_tx_rd(core_tx_rd),
      .core_tx_data(core_tx_data), .core_tx_avail(core_tx_avail),
      .core_rx_wr(core_rx_wr), .core_rx_data(core_rx_data), .core_rx_space(core_rx_space),
      .tx_thresh(tx_thresh), .rx_thresh(rx_thresh), .tx_dma_en(tx_dma_en),
      .rx_dma_en(rx_dma_en), .tx_drain_en(tx_drain_en), .rx_drain_en(rx_drain_en),
      .tx_clr(tx_clr), .rx_clr(rx_clr), .tx_remain(tx_remain), .xfer_done(xfer_done),
      .flag_clr(flag_clr), .irq_mask(irq_mask), .raw_flags(raw_flags), .irq(irq),
      .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req), .tx_level(tx_level),
      .rx_level(rx_level), .fifo_depth(fifo_depth)
   );

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic core_push(input logic [7:0] d);
      core_rx_wr = 1; core_rx_data = d; step(); core_rx_wr = 0;
   endtask

   task automatic host_read(output logic [7:0] d);
      d = host_rdata; host_rd = 1; step(); host_rd = 0;
   endtask

   task automatic host_write(input logic [7:0] d);
      host_wr = 1; host_wdata = d; step(); host_wr = 0;
   endtask

   task automatic clear_flags(input logic [4:0] m);
      flag_clr = m; step(); flag_clr = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      summary();
   end

   initial begin
      logic [7:0] d;
      logic [4:0] snap;
      repeat (3) @(posedge clk);
      #1;
      // reset state
      chk("R1 depth", fifo_depth, DEPTH);
      chk("R3 reset flags", raw_flags, 0);
      chk("R1 reset rx level", rx_level, 0);
      chk("R5 reset tx dma", tx_dma_req, 0);
      chk("R10 reset rx space", core_rx_space, 1);
      rst_n = 1;
      step();

      // receive side sweep
      for (int th = 0; th < DEPTH; th++) begin
         rx_thresh = TW'(th); rx_dma_en = 1;
         rx_clr = 1; step(); rx_clr = 0;
         clear_flags(5'h1f);
         for (int k = 1; k <= DEPTH; k++) begin
            core_push(8'(th * 16 + k));
            step();
            chk("R1 rx level", rx_level, k);
            chk("R2 rx ready", raw_flags[0], int'(k >= th + 1));
            chk("R4 rx dma rise", rx_dma_req, int'(k >= th + 1));
         end
         for (int j = 0; j <= th; j++) begin
            host_read(d);
            chk("R1 rx order", d, th * 16 + j + 1);
            chk("R4 rx dma burst", rx_dma_req, int'(j < th));
         end
         step();
         chk("R4 rx dma rearm", rx_dma_req, int'(DEPTH - th - 1 >= th + 1));
         for (int j = th + 1; j < DEPTH; j++) begin
            host_read(d);
            chk("R1 rx order tail", d, th * 16 + j + 1);
         end
         host_rd = 1; step(); host_rd = 0;
         chk("R6 rx underflow flag", raw_flags[4], 1);
         chk("R6 rx level kept", rx_level, 0);
         clear_flags(5'h11);
         chk("R3 clear accerr", raw_flags[4], 0);
         chk("R3 clear rx ready", raw_flags[0], 0);
         for (int j = 0; j <= th; j++) core_push(8'(j));
         step();
         clear_flags(5'h01);
         chk("R3 rearm while held", raw_flags[0], 1);
         rx_clr = 1; step(); rx_clr = 0;
         chk("R9 rx flush level", rx_level, 0);
         chk("R9 rx flush dma", rx_dma_req, 0);
      end
      rx_dma_en = 0;

      // transmit side sweep
      for (int th = 0; th < DEPTH; th++) begin
         tx_thresh = TW'(th); tx_dma_en = 1;
         tx_clr = 1; step(); tx_clr = 0;
         step();
         chk("R5 tx dma on empty", tx_dma_req, 1);
         for (int j = 0; j <= th; j++) begin
            host_write(8'(th * 16 + j));
            chk("R5 tx dma burst", tx_dma_req, int'(j < th));
         end
         chk("R10 tx avail", core_tx_avail, 1);
         chk("R1 tx level", tx_level, th + 1);
         clear_flags(5'h02);
         chk("R12 tx ready", raw_flags[1], int'(DEPTH - th - 1 >= th + 1));
         for (int j = 0; j <= th; j++) begin
            chk("R1 tx order", core_tx_data, th * 16 + j);
            core_tx_rd = 1; step(); core_tx_rd = 0;
         end
         chk("R10 tx avail empty", core_tx_avail, 0);
         step();
         chk("R5 tx dma rearm", tx_dma_req, 1);
         for (int j = 0; j < DEPTH; j++) host_write(8'(j));
         chk("R10 rx space", core_rx_space, 1);
         host_write(8'hee);
         chk("R6 tx overflow flag", raw_flags[4], 1);
         chk("R6 tx level kept", tx_level, DEPTH);
         tx_clr = 1; step(); tx_clr = 0;
         chk("R9 tx flush level", tx_level, 0);
         chk("R9 tx flush dma", tx_dma_req, 0);
         clear_flags(5'h1f);
      end
      tx_dma_en = 0;

      // receive drain sweep
      for (int en = 0; en < 2; en++)
         for (int th = 0; th < DEPTH; th++)
            for (int n = 0; n <= DEPTH; n++) begin
               rx_thresh = TW'(th); rx_drain_en = en[0];
               rx_clr = 1; step(); rx_clr = 0;
               clear_flags(5'h04);
               for (int j = 0; j < n; j++) core_push(8'(j));
               xfer_done = 1; step(); xfer_done = 0;
               chk("R7 rx drain flag", raw_flags[2], int'(en == 1 && n > 0 && n < th + 1));
               chk("R7 rx drain count", rx_level, n);
            end
      rx_drain_en = 0;
      rx_clr = 1; step(); rx_clr = 0;

      // transmit drain sweep
      for (int en = 0; en < 2; en++)
         for (int th = 0; th < DEPTH; th++)
            for (int r = 0; r <= DEPTH + 1; r++) begin
               tx_remain = 0; tx_thresh = TW'(th); tx_drain_en = en[0];
               clear_flags(5'h08);
               tx_remain = 8'(r);
               step();
               chk("R8 tx drain flag", raw_flags[3], int'(en == 1 && r > 0 && r < th + 1));
            end
      tx_remain = 0; tx_drain_en = 0;

      // interrupt mask sweep
      clear_flags(5'h1f);
      host_rd = 1; step(); host_rd = 0;
      step();
      snap = raw_flags;
      chk("R11 raw flags known", snap, 5'h12);
      for (int m = 0; m < 32; m++) begin
         irq_mask = 5'(m);
         step();
         chk("R11 irq", irq, int'((5'h12 & 5'(m)) != 0));
         chk("R11 raw unaffected", raw_flags, snap);
      end
      summary();
   end
endmodule